// File: doc/BRIEF.md
# Gapped-Clock Jitter Attenuator FIFO

This block is a shallow elastic store, two bits per entry, placed in one serial data path of a line interface. The write side accepts a symbol on every cycle where the path's write enable is high. That enable may come in bursts with long gaps. The read side removes one symbol on every cycle where an externally smoothed read enable is high. The block starts with the store half full, so every symbol spends a fixed half-depth number of read slots inside it. This constant latency is what allows hitless switching between equivalent sources.

A configuration bit chooses the long or the short depth. A hardware strap forces the long depth. A two-bit placement field routes the store into the transmit path or the receive path, or takes it out of both. When it is out of both, the two paths pass straight through and the store is held in its reset state. The current fill level is exported so that an outside clock-smoothing loop can use it as a phase-error term. Overflow and underflow are detected, recentre the store, and set sticky flags.

Top module: `gapclk_jitter_fifo`

## Requirements
- R1: Each entry holds a 2-bit symbol, and all four symbol values travel through the store unchanged.
- R2: The depth D is DEPTH_MAX when `deepSel` or `hwStrap` is 1, and DEPTH_MAX/2 when both are 0. `hwStrap`=1 forces the long depth whatever `deepSel` is.
- R3: After a recentre, reads return 0 for the first D/2 read slots. After that, read slot n returns the symbol taken by write slot n−D/2. The read symbol appears on the path output one clock after the read enable.
- R4: Starting from a recentre, up to D/2 consecutive read slots without a write are tolerated with no error, and the fill level falls by one per slot.
- R5: A write with no simultaneous read while the fill level equals D is an overflow. It sets `ovfFlag`, discards the write and returns the fill level to D/2 on the next clock.
- R6: A read while the fill level is 0 is an underflow, even when a write occurs in the same cycle. It sets `udfFlag` and returns the fill level to D/2 on the next clock.
- R7: `ovfFlag` and `udfFlag` stay set until a cycle with `clrErr`=1 clears them.
- R8: On reset, and one clock after any change of effective depth or placement, the fill level becomes D/2 and all entries and the read register are cleared. A change of placement or depth also clears both flags.
- R9: Placement 2'b00 or 2'b11 is bypass. In bypass `txOut`=`txIn` and `rxOut`=`rxIn` combinationally, the fill level stays at D/2, the enables have no effect, and both flags are cleared.
- R10: Placement 2'b01 puts the store in the transmit path, written by `txInEn`. Placement 2'b10 puts it in the receive path, written by `rxInEn`. The other path passes through combinationally.
- R11: `fill` equals D/2 plus the writes minus the reads accepted since the last recentre, and it never exceeds D.
- R12: A cycle with both a write and a read leaves the fill level unchanged, including at level D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hwStrap | input | 1 | Forces long depth |
| deepSel | input | 1 | 1 = long depth, 0 = short depth |
| placeSel | input | 2 | 00/11 bypass, 01 transmit path, 10 receive path |
| clrErr | input | 1 | Clears the sticky flags |
| txIn | input | 2 | Transmit path symbol in |
| txInEn | input | 1 | Transmit write enable |
| txOut | output | 2 | Transmit path symbol out |
| rxIn | input | 2 | Receive path symbol in |
| rxInEn | input | 1 | Receive write enable |
| rxOut | output | 2 | Receive path symbol out |
| rdEn | input | 1 | Smoothed read enable |
| fill | output | clog2(DEPTH_MAX)+1 | Current fill level |
| ovfFlag | output | 1 | Sticky overflow |
| udfFlag | output | 1 | Sticky underflow |

## Verification
The bench builds the block with DEPTH_MAX=16, so the two depths are 8 and 16 and the half points are 4 and 8. With depths this small, every pointer wrap, the completely full and completely empty levels, and both error recoveries are reached within a few dozen cycles in each configuration. All depth, strap and placement combinations can therefore be swept, together with all sixteen symbol pairs in bypass.

// File: rtl/jaf_pkg.sv
package jaf_pkg;
  localparam logic [1:0] PL_OFF = 2'b00;
  localparam logic [1:0] PL_TX  = 2'b01;
  localparam logic [1:0] PL_RX  = 2'b10;

  // control-to-datapath strobes
  typedef struct packed {
    logic recentre;
    logic doWr;
    logic doRd;
    logic deep;
  } jafStrb_t;
endpackage

// File: rtl/jaf_ctrl.sv
module jaf_ctrl import jaf_pkg::*; #(
  parameter int DEPTH_MAX = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hwStrap,
  input  logic                        deepSel,
  input  logic [1:0]                  placeSel,
  input  logic                        wrReq,
  input  logic                        rdReq,
  input  logic                        clrErr,
  output jafStrb_t                    strb,
  output logic [$clog2(DEPTH_MAX):0]  fill,
  output logic                        ovfFlag,
  output logic                        udfFlag
);
  localparam int AW   = $clog2(DEPTH_MAX);
  localparam int LW   = AW + 1;
  localparam int DMIN = DEPTH_MAX / 2;

  logic          deepNow, bypass, cfgChg, hold, ovfNow, udfNow;
  logic [LW-1:0] depthNow, halfNow, lvl;
  logic          cfgDeepQ;
  logic [1:0]    cfgPlaceQ;

  assign deepNow  = hwStrap | deepSel;
  assign depthNow = deepNow ? LW'(DEPTH_MAX) : LW'(DMIN);
  assign halfNow  = depthNow >> 1;
  assign bypass   = (placeSel != PL_TX) && (placeSel != PL_RX);
  assign cfgChg   = {deepNow, placeSel} != {cfgDeepQ, cfgPlaceQ};
  assign hold     = bypass | cfgChg;
  assign ovfNow   = !hold & wrReq & !rdReq & (lvl == depthNow);
  assign udfNow   = !hold & rdReq & (lvl == '0);

  always_comb begin
    strb.recentre = hold | ovfNow | udfNow;
    strb.doWr     = wrReq & !strb.recentre;
    strb.doRd     = rdReq & !strb.recentre;
    strb.deep     = deepNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDeepQ  <= 1'b0;
      cfgPlaceQ <= PL_OFF;
      lvl       <= LW'(DMIN / 2);
      ovfFlag   <= 1'b0;
      udfFlag   <= 1'b0;
    end else begin
      cfgDeepQ  <= deepNow;
      cfgPlaceQ <= placeSel;
      if (strb.recentre) lvl <= halfNow;
      else if (strb.doWr && !strb.doRd) lvl <= lvl + 1'b1;
      else if (strb.doRd && !strb.doWr) lvl <= lvl - 1'b1;
      if (hold) begin
        ovfFlag <= 1'b0;
        udfFlag <= 1'b0;
      end else begin
        ovfFlag <= ovfNow | (ovfFlag & !clrErr);
        udfFlag <= udfNow | (udfFlag & !clrErr);
      end
    end
  end

  assign fill = lvl;

  a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    !cfgChg |-> lvl <= depthNow);
  a_r5_ovf_recentre: assert property (@(posedge clk) disable iff (!rstN)
    ovfNow |=> (lvl == $past(halfNow)) && ovfFlag);
  a_r6_udf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    udfNow |=> udfFlag && (lvl == $past(halfNow)));
  a_r12_level_keep: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.recentre && wrReq && rdReq) |=> lvl == $past(lvl));
  a_r9_bypass_clears: assert property (@(posedge clk) disable iff (!rstN)
    bypass |=> !ovfFlag && !udfFlag);
endmodule

// File: rtl/jaf_dpath.sv
module jaf_dpath import jaf_pkg::*; #(
  parameter int DEPTH_MAX = 64,
  parameter int DW        = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  jafStrb_t      strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int AW   = $clog2(DEPTH_MAX);
  localparam int DMIN = DEPTH_MAX / 2;

  logic [DW-1:0] mem [DEPTH_MAX];
  logic [AW-1:0] wp, rp, mask, half;

  assign mask = strb.deep ? AW'(DEPTH_MAX - 1) : AW'(DMIN - 1);
  assign half = strb.deep ? AW'(DEPTH_MAX / 2) : AW'(DMIN / 2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp     <= AW'(DMIN / 2);
      rp     <= '0;
      rdData <= '0;
      for (int i = 0; i < DEPTH_MAX; i++) mem[i] <= '0;
    end else if (strb.recentre) begin
      wp     <= half;
      rp     <= '0;
      rdData <= '0;
      for (int i = 0; i < DEPTH_MAX; i++) mem[i] <= '0;
    end else begin
      if (strb.doWr) begin
        mem[wp] <= wrData;
        wp      <= AW'(wp + 1'b1) & mask;
      end
      if (strb.doRd) begin
        rdData <= mem[rp];
        rp     <= AW'(rp + 1'b1) & mask;
      end
    end
  end

  // R2: in the short depth both pointers stay inside the lower half
  a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.deep && !strb.recentre) |-> (wp < AW'(DMIN)) && (rp < AW'(DMIN)));
endmodule

// File: rtl/gapclk_jitter_fifo.sv
module gapclk_jitter_fifo import jaf_pkg::*; #(
  parameter int DEPTH_MAX = 64,
  parameter int DW        = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hwStrap,
  input  logic                        deepSel,
  input  logic [1:0]                  placeSel,
  input  logic                        clrErr,
  input  logic [DW-1:0]               txIn,
  input  logic                        txInEn,
  output logic [DW-1:0]               txOut,
  input  logic [DW-1:0]               rxIn,
  input  logic                        rxInEn,
  output logic [DW-1:0]               rxOut,
  input  logic                        rdEn,
  output logic [$clog2(DEPTH_MAX):0]  fill,
  output logic                        ovfFlag,
  output logic                        udfFlag
);
  jafStrb_t      strb;
  logic          inTx, inRx, wrReq, rdReq;
  logic [DW-1:0] wrData, rdData;

  assign inTx   = placeSel == PL_TX;
  assign inRx   = placeSel == PL_RX;
  assign wrReq  = (inTx & txInEn) | (inRx & rxInEn);
  assign rdReq  = rdEn & (inTx | inRx);
  assign wrData = inTx ? txIn : rxIn;
  assign txOut  = inTx ? rdData : txIn;
  assign rxOut  = inRx ? rdData : rxIn;

  jaf_ctrl #(.DEPTH_MAX(DEPTH_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .hwStrap(hwStrap), .deepSel(deepSel),
    .placeSel(placeSel), .wrReq(wrReq), .rdReq(rdReq), .clrErr(clrErr),
    .strb(strb), .fill(fill), .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  jaf_dpath #(.DEPTH_MAX(DEPTH_MAX), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/sim_gapclk_jitter_fifo.sv
`timescale 1ns/1ps
module sim_gapclk_jitter_fifo;
  localparam int DM = 16;
  localparam int FW = $clog2(DM) + 1;

  logic clk = 0, rstN = 0, hwStrap = 0, deepSel = 0, clrErr = 0;
  logic txInEn = 0, rxInEn = 0, rdEn = 0;
  logic [1:0] placeSel = 2'b01, txIn = 0, rxIn = 0;
  logic [1:0] txOut, rxOut;
  logic [FW-1:0] fill;
  logic ovfFlag, udfFlag;
  int total = 0, bad = 0;
  bit finished = 0;

  gapclk_jitter_fifo #(.DEPTH_MAX(DM), .DW(2)) u0 (
    .clk(clk), .rstN(rstN), .hwStrap(hwStrap), .deepSel(deepSel),
    .placeSel(placeSel), .clrErr(clrErr), .txIn(txIn), .txInEn(txInEn),
    .txOut(txOut), .rxIn(rxIn), .rxInEn(rxInEn), .rxOut(rxOut),
    .rdEn(rdEn), .fill(fill), .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc; @(negedge clk); endtask
  task automatic idle; txInEn = 0; rxInEn = 0; rdEn = 0; clrErr = 0; endtask

  task automatic wrapUp;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic sweep(input bit dp, input bit st, input logic [1:0] pl);
    int h, exp, act, oth, othExp;
    int hist[64];
    h = (dp | st) ? DM / 2 : DM / 4;
    idle(); deepSel = dp; hwStrap = st; placeSel = pl;
    cyc(); cyc();
    chk(fill == h, "R2 R8 recentre level", int'(fill), h);
    for (int n = 0; n < 40; n++) begin
      hist[n] = (n * 3 + dp + pl) & 3;
      if (pl == 2'b01) begin
        txIn = 2'(hist[n]); txInEn = 1; rxIn = 2'(n & 3);
      end else begin
        rxIn = 2'(hist[n]); rxInEn = 1; txIn = 2'(n & 3);
      end
      rdEn = 1;
      cyc();
      exp = (n < h) ? 0 : hist[n - h];
      act = (pl == 2'b01) ? int'(txOut) : int'(rxOut);
      chk(act == exp, "R1 R3 delayed symbol", act, exp);
      oth    = (pl == 2'b01) ? int'(rxOut) : int'(txOut);
      othExp = (pl == 2'b01) ? int'(rxIn) : int'(txIn);
      chk(oth == othExp, "R10 other path passes", oth, othExp);
      chk(fill == h, "R12 level steady", int'(fill), h);
    end
    idle();
  endtask

  task automatic errs(input bit dp);
    int h, d;
    d = dp ? DM : DM / 2;
    h = d / 2;
    idle(); hwStrap = 0; deepSel = dp; placeSel = 2'b00; cyc();
    placeSel = 2'b01; cyc(); cyc();
    chk(fill == h, "R8 fresh level", int'(fill), h);
    for (int g = 1; g <= h; g++) begin
      rdEn = 1; cyc();
      chk(fill == h - g, "R4 gap drains level", int'(fill), h - g);
      chk(udfFlag == 0, "R4 no underflow in gap", int'(udfFlag), 0);
    end
    rdEn = 1; txInEn = 1; cyc();
    chk(udfFlag == 1, "R6 underflow flagged", int'(udfFlag), 1);
    chk(fill == h, "R6 recentred", int'(fill), h);
    idle(); cyc();
    chk(udfFlag == 1, "R7 underflow sticky", int'(udfFlag), 1);
    clrErr = 1; cyc(); clrErr = 0;
    chk(udfFlag == 0, "R7 underflow cleared", int'(udfFlag), 0);
    for (int k = 0; k < d - h; k++) begin
      txInEn = 1; cyc();
      chk(ovfFlag == 0, "R11 no overflow filling", int'(ovfFlag), 0);
    end
    chk(fill == d, "R11 full level", int'(fill), d);
    txInEn = 1; rdEn = 1; cyc();
    chk(fill == d, "R12 full with read and write", int'(fill), d);
    chk(ovfFlag == 0, "R12 no overflow", int'(ovfFlag), 0);
    rdEn = 0; cyc();
    chk(ovfFlag == 1, "R5 overflow flagged", int'(ovfFlag), 1);
    chk(fill == h, "R5 recentred", int'(fill), h);
    idle(); cyc();
    chk(ovfFlag == 1, "R7 overflow sticky", int'(ovfFlag), 1);
    placeSel = 2'b00; cyc();
    chk(ovfFlag == 0, "R9 bypass clears flag", int'(ovfFlag), 0);
    idle();
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1;
    cyc(); cyc();
    chk(fill == DM / 4, "R8 reset level", int'(fill), DM / 4);
    chk(txOut == 0, "R3 reset output", int'(txOut), 0);
    chk(ovfFlag == 0 && udfFlag == 0, "R5 R6 reset flags", int'({ovfFlag, udfFlag}), 0);

    sweep(0, 0, 2'b01);
    sweep(1, 0, 2'b01);
    sweep(0, 0, 2'b10);
    sweep(1, 0, 2'b10);
    sweep(0, 1, 2'b01);
    sweep(0, 1, 2'b10);
    errs(0);
    errs(1);

    deepSel = 1;
    for (int p = 0; p < 2; p++) begin
      placeSel = (p == 0) ? 2'b00 : 2'b11;
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          txIn = 2'(a); rxIn = 2'(b);
          txInEn = 1; rxInEn = 1; rdEn = 1;
          #1;
          chk(txOut == a, "R9 tx bypass", int'(txOut), a);
          chk(rxOut == b, "R9 rx bypass", int'(rxOut), b);
          cyc();
          chk(fill == DM / 2, "R9 level held", int'(fill), DM / 2);
        end
      end
    end
    idle();
    wrapUp();
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    wrapUp();
  end
endmodule